// File: doc/BRIEF.md
# Interleaved Line Fetcher

This block moves one cache line of four words between a requester and a memory built from word-interleaved banks. The requester presents a line-aligned line address with a valid pulse while the block is idle. The block spends one cycle issuing the address. The banks then perform their fixed-latency access, and for a read the words come back over a one-word return path, one word per cycle, lowest word first. Word `w` of line `L` lives at word address `4*L + w`, and in the interleaved build that word sits in bank `w` (the word address modulo 4), at row `L`.

Because all banks start in the same cycle, a read costs one address cycle, one access time and then one cycle per word. A build parameter replaces the four banks with one bank of four times the depth. In that build each word takes its own address cycle, full access and transfer before the next word begins. A line write hands one word to each bank, and each bank finishes storing it one access time later. A cycle counter restarts at each accepted request so the line latency can be read at the ports.

Top module: `ilv_line_fetch`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `line_done` are low and `cyc_count` is 0.
- R2: A read returns the four words of the addressed line in word order 0,1,2,3. Word `w` of line `L` is the value last written to word address `4*L+w`, which is held in bank `(4*L+w) mod 4` when interleaved.
- R3: Interleaved read (access latency 15): the cycle after acceptance is cycle 1, and word `i` is strobed on `rd_valid` in cycle `17+i`. `busy` is high for exactly 20 cycles.
- R4: Single-bank read: word `i` is strobed in cycle `17*(i+1)`. `busy` is high for exactly 68 cycles.
- R5: Interleaved write: `busy` is high for exactly 16 cycles, `line_done` pulses in cycle 16, and a later read of the line returns the written words. Word `w` is taken from bits `[32*w+31:32*w]` of `req_wdata`.
- R6: Single-bank write: `busy` is high for exactly 64 cycles and `line_done` pulses in cycle 64.
- R7: A request presented while `busy` is high is ignored. It changes neither the running operation's data or timing nor memory contents, and it starts no new operation.
- R8: `line_done` pulses exactly once per operation, in its last busy cycle. It coincides with the fourth `rd_valid` for a read, and `rd_valid` never rises during a write.
- R9: `cyc_count` is 1 in the address cycle, rises by one in each further busy cycle, and holds its final value while idle.
- R10: In the interleaved build all banks begin their access in the same cycle, so the read latency does not grow with the number of words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Line request, taken only when idle |
| req_write | input | 1 | 1 = line write, 0 = line read |
| req_line | input | LINE_ADDR_W | Line address |
| req_wdata | input | LINE_WORDS*WORD_W | Write line, word w at bits [WORD_W*w +: WORD_W] |
| busy | output | 1 | High from the address cycle to the last cycle of the operation |
| rd_valid | output | 1 | Marks a returned word on rd_data |
| rd_data | output | WORD_W | Returned read word |
| line_done | output | 1 | Pulse in the last cycle of an operation |
| cyc_count | output | CNT_W | Cycles since the request, 1 in the address cycle |

## Verification
The bench targets the exact cycle of every strobe in both builds. If the banks were started one after another, the interleaved read would stretch toward 68 cycles. An off-by-one in the access counter would shift every word and change `cyc_count` at completion. Requests are injected mid-operation with an inverted line, inverted data and the opposite direction. A controller that re-latched them would return wrong words, corrupt the other line, or stay busy after the expected last cycle. Writes to line 0, the last line and all-ones data, each read back, catch bank or row mapping slips that would swap words between banks.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_XFER = 2'd3
    } fetch_state_e;
endpackage

// File: rtl/ilv_bank.sv
// One storage bank with a fixed access latency counted from its start pulse.
module ilv_bank #(
    parameter int WORD_W  = 32,
    parameter int DEPTH   = 16,
    parameter int ACC_LAT = 15,
    localparam int ROW_W  = $clog2(DEPTH),
    localparam int LCNT_W = $clog2(ACC_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              acc_last
);
    typedef struct packed {
        logic [LCNT_W-1:0] cnt;
        logic              we;
        logic [ROW_W-1:0]  row;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
    } bank_regs_t;

    bank_regs_t bank_d, bank_q;
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_comb begin
        bank_d = bank_q;
        if (bank_q.cnt != '0)
            bank_d.cnt = bank_q.cnt - LCNT_W'(1);
        if (bank_q.cnt == LCNT_W'(1) && !bank_q.we)
            bank_d.rdata = mem_q[bank_q.row];
        if (start) begin
            bank_d.cnt   = LCNT_W'(ACC_LAT);
            bank_d.we    = we;
            bank_d.row   = row;
            bank_d.wdata = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_ff @(posedge clk) begin
        if (bank_q.cnt == LCNT_W'(1) && bank_q.we)
            mem_q[bank_q.row] <= bank_q.wdata;
    end

    assign rdata    = bank_q.rdata;
    assign acc_last = (bank_q.cnt == LCNT_W'(1));

    // R10
    bank_idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (bank_q.cnt == '0));
endmodule

// File: rtl/ilv_ctrl.sv
// Sequencer: address cycle, bank access wait, word transfer.
module ilv_ctrl
    import ilv_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int NW      = 4,
    parameter int NB      = 4,
    parameter int LADDR_W = 4,
    parameter int CNT_W   = 8,
    localparam int IW     = $clog2(NW),
    localparam int BSH    = $clog2(NB),
    localparam int ROW_W  = LADDR_W + IW - BSH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [LADDR_W-1:0]   req_line,
    input  logic [NW*WORD_W-1:0] req_wdata,
    output logic                 busy,
    output logic                 rd_valid,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 line_done,
    output logic [CNT_W-1:0]     cyc_count,
    output logic [NB-1:0]        bank_start,
    output logic                 bank_we,
    output logic [ROW_W-1:0]     bank_row,
    output logic [NB*WORD_W-1:0] bank_wdata,
    input  logic [NB*WORD_W-1:0] bank_rdata,
    input  logic [NB-1:0]        bank_last
);
    typedef struct packed {
        fetch_state_e          state;
        logic                  wr;
        logic [LADDR_W-1:0]    line;
        logic [IW-1:0]         idx;
        logic [NW*WORD_W-1:0]  wbuf;
        logic [CNT_W-1:0]      cnt;
    } ctrl_regs_t;

    ctrl_regs_t ctrl_d, ctrl_q;
    logic [LADDR_W+IW-1:0] waddr;
    logic last_word;

    always_comb begin
        ctrl_d    = ctrl_q;
        line_done = 1'b0;
        rd_valid  = 1'b0;
        rd_data   = '0;
        waddr     = {ctrl_q.line, ctrl_q.idx};
        bank_row  = ROW_W'(waddr >> BSH);
        bank_start = {NB{ctrl_q.state == ST_ADDR}};
        bank_we   = ctrl_q.wr;
        for (int b = 0; b < NB; b++)
            bank_wdata[b*WORD_W +: WORD_W] = ctrl_q.wbuf[b*WORD_W +: WORD_W];
        if (NB == 1) begin
            for (int w = 0; w < NW; w++)
                if (IW'(w) == ctrl_q.idx)
                    bank_wdata[0 +: WORD_W] = ctrl_q.wbuf[w*WORD_W +: WORD_W];
        end
        last_word = (NB == NW) || (ctrl_q.idx == IW'(NW - 1));

        case (ctrl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.state = ST_ADDR;
                    ctrl_d.wr    = req_write;
                    ctrl_d.line  = req_line;
                    ctrl_d.wbuf  = req_wdata;
                    ctrl_d.idx   = '0;
                    ctrl_d.cnt   = CNT_W'(1);
                end
            end
            ST_ADDR: begin
                ctrl_d.state = ST_WAIT;
                ctrl_d.cnt   = ctrl_q.cnt + CNT_W'(1);
            end
            ST_WAIT: begin
                if (&bank_last) begin
                    if (ctrl_q.wr) begin
                        if (last_word) begin
                            line_done    = 1'b1;
                            ctrl_d.state = ST_IDLE;
                        end else begin
                            ctrl_d.idx   = ctrl_q.idx + IW'(1);
                            ctrl_d.state = ST_ADDR;
                            ctrl_d.cnt   = ctrl_q.cnt + CNT_W'(1);
                        end
                    end else begin
                        ctrl_d.state = ST_XFER;
                        ctrl_d.cnt   = ctrl_q.cnt + CNT_W'(1);
                    end
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + CNT_W'(1);
                end
            end
            default: begin
                rd_valid = 1'b1;
                for (int b = 0; b < NB; b++)
                    if (NB == 1 || IW'(b) == ctrl_q.idx)
                        rd_data = bank_rdata[b*WORD_W +: WORD_W];
                if (ctrl_q.idx == IW'(NW - 1)) begin
                    line_done    = 1'b1;
                    ctrl_d.state = ST_IDLE;
                end else begin
                    ctrl_d.idx   = ctrl_q.idx + IW'(1);
                    ctrl_d.state = (NB == NW) ? ST_XFER : ST_ADDR;
                    ctrl_d.cnt   = ctrl_q.cnt + CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign busy      = (ctrl_q.state != ST_IDLE);
    assign cyc_count = ctrl_q.cnt;

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cyc_count == $past(cyc_count) + CNT_W'(1)));
    // R7
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ctrl_q.line) && $stable(ctrl_q.wr)));
    // R8
    no_wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !ctrl_q.wr);
    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> busy);
endmodule

// File: rtl/ilv_line_fetch.sv
module ilv_line_fetch #(
    parameter int WORD_W      = 32,
    parameter int LINE_WORDS  = 4,
    parameter int LINE_ADDR_W = 4,
    parameter int ACC_LAT     = 15,
    parameter bit INTERLEAVE  = 1'b1,
    parameter int CNT_W       = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [LINE_ADDR_W-1:0]       req_line,
    input  logic [LINE_WORDS*WORD_W-1:0] req_wdata,
    output logic                         busy,
    output logic                         rd_valid,
    output logic [WORD_W-1:0]            rd_data,
    output logic                         line_done,
    output logic [CNT_W-1:0]             cyc_count
);
    localparam int NB    = INTERLEAVE ? LINE_WORDS : 1;
    localparam int DEPTH = (2 ** LINE_ADDR_W) * LINE_WORDS / NB;
    localparam int ROW_W = $clog2(DEPTH);

    logic [NB-1:0]        bank_start, bank_last;
    logic                 bank_we;
    logic [ROW_W-1:0]     bank_row;
    logic [NB*WORD_W-1:0] bank_wdata, bank_rdata;

    ilv_ctrl #(
        .WORD_W(WORD_W), .NW(LINE_WORDS), .NB(NB),
        .LADDR_W(LINE_ADDR_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_line(req_line), .req_wdata(req_wdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .line_done(line_done), .cyc_count(cyc_count),
        .bank_start(bank_start), .bank_we(bank_we), .bank_row(bank_row),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata), .bank_last(bank_last)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        ilv_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ACC_LAT(ACC_LAT)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .start(bank_start[b]), .we(bank_we), .row(bank_row),
            .wdata(bank_wdata[b*WORD_W +: WORD_W]),
            .rdata(bank_rdata[b*WORD_W +: WORD_W]),
            .acc_last(bank_last[b])
        );
    end

    if (NB > 1) begin : g_sync_chk
        // R10
        bank_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|bank_start) |-> (&bank_start));
    end
endmodule

// File: tb/ilv_line_fetch_tb.sv
`timescale 1ns/1ps
module ilv_line_fetch_tb;
    localparam int WW = 32, NW = 4, LA = 4, LAT = 15, CW = 8, NL = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, req_a, req_b, req_write;
    logic [LA-1:0]    req_line;
    logic [NW*WW-1:0] req_wdata;
    logic busy_a, rdv_a, done_a, busy_b, rdv_b, done_b;
    logic [WW-1:0] rdd_a, rdd_b;
    logic [CW-1:0] cyc_a, cyc_b;

    ilv_line_fetch #(.INTERLEAVE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_a), .req_write(req_write),
        .req_line(req_line), .req_wdata(req_wdata), .busy(busy_a),
        .rd_valid(rdv_a), .rd_data(rdd_a), .line_done(done_a), .cyc_count(cyc_a));

    ilv_line_fetch #(.INTERLEAVE(1'b0)) u_dut_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_b), .req_write(req_write),
        .req_line(req_line), .req_wdata(req_wdata), .busy(busy_b),
        .rd_valid(rdv_b), .rd_data(rdd_b), .line_done(done_b), .cyc_count(cyc_b));

    logic sel_ilv;
    wire cur_busy = sel_ilv ? busy_a : busy_b;
    wire cur_rdv  = sel_ilv ? rdv_a  : rdv_b;
    wire cur_done = sel_ilv ? done_a : done_b;
    wire [WW-1:0] cur_rdd = sel_ilv ? rdd_a : rdd_b;
    wire [CW-1:0] cur_cyc = sel_ilv ? cyc_a : cyc_b;

    logic [WW-1:0] model [NL*NW];
    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_word_cycle(input bit ilv, input int i);
        return ilv ? (LAT + 2 + i) : (LAT + 2) * (i + 1);
    endfunction

    function automatic int exp_busy(input bit ilv, input bit wr);
        if (ilv) return wr ? (LAT + 1) : (LAT + 1 + NW);
        return wr ? (LAT + 1) * NW : (LAT + 2) * NW;
    endfunction

    function automatic logic [NW*WW-1:0] rand_line();
        logic [NW*WW-1:0] v;
        for (int w = 0; w < NW; w++) v[w*WW +: WW] = $urandom;
        return v;
    endfunction

    task automatic run_op(input bit ilv, input bit wr, input logic [LA-1:0] line,
                          input logic [NW*WW-1:0] data, input bit poke);
        int n, wi, done_n, done_cnt, cnt_bad, strobe_bad;
        string tag;
        tag = ilv ? (wr ? "R5" : "R3 R10") : (wr ? "R6" : "R4");
        @(negedge clk);
        sel_ilv = ilv; req_write = wr; req_line = line; req_wdata = data;
        if (ilv) req_a = 1'b1; else req_b = 1'b1;
        @(negedge clk);
        req_a = 1'b0; req_b = 1'b0;
        n = 1; wi = 0; done_n = 0; done_cnt = 0; cnt_bad = 0; strobe_bad = 0;
        while (cur_busy && n < 200) begin
            if (cur_cyc != CW'(n)) cnt_bad++;
            if (cur_rdv) begin
                if (wr || wi >= NW) strobe_bad++;
                else begin
                    chk(n == exp_word_cycle(ilv, wi), tag, 64'(n), 64'(exp_word_cycle(ilv, wi)));
                    chk(cur_rdd == model[int'(line) * NW + wi], "R2", 64'(cur_rdd),
                        64'(model[int'(line) * NW + wi]));
                    wi++;
                end
            end
            if (cur_done) begin done_n = n; done_cnt++; end
            if (poke && n == 5) begin
                req_write = ~wr; req_line = ~line; req_wdata = ~data;
                if (ilv) req_a = 1'b1; else req_b = 1'b1;
            end
            if (poke && n == 6) begin req_a = 1'b0; req_b = 1'b0; end
            @(negedge clk);
            n++;
        end
        chk(n - 1 == exp_busy(ilv, wr), poke ? {tag, " R7"} : tag, 64'(n - 1), 64'(exp_busy(ilv, wr)));
        chk(done_cnt == 1 && done_n == exp_busy(ilv, wr), "R8", 64'(done_n), 64'(exp_busy(ilv, wr)));
        chk(strobe_bad == 0 && wi == (wr ? 0 : NW), "R8", 64'(wi), 64'(wr ? 0 : NW));
        chk(cnt_bad == 0 && cur_cyc == CW'(exp_busy(ilv, wr)), "R9", 64'(cur_cyc), 64'(exp_busy(ilv, wr)));
        if (poke) begin
            @(negedge clk);
            chk(!cur_busy, "R7", 64'(cur_busy), 64'd0);
        end
        if (wr)
            for (int w = 0; w < NW; w++) model[int'(line) * NW + w] = data[w*WW +: WW];
    endtask

    task automatic both(input bit wr, input logic [LA-1:0] line, input logic [NW*WW-1:0] data);
        run_op(1'b1, wr, line, data, 1'b0);
        run_op(1'b0, wr, line, data, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [NW*WW-1:0] d;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; req_a = 1'b0; req_b = 1'b0; req_write = 1'b0;
        req_line = '0; req_wdata = '0; sel_ilv = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state on both builds
        chk(!busy_a && !rdv_a && !done_a && cyc_a == 0, "R1", {busy_a, rdv_a, done_a, cyc_a}, 64'd0);
        chk(!busy_b && !rdv_b && !done_b && cyc_b == 0, "R1", {busy_b, rdv_b, done_b, cyc_b}, 64'd0);

        for (int l = 0; l < NL; l++) both(1'b1, LA'(l), rand_line());

        // directed corners: first and last line, all ones, all zeros
        both(1'b0, '0, '0);
        both(1'b0, LA'(NL - 1), '0);
        both(1'b1, LA'(NL - 1), '1);
        both(1'b0, LA'(NL - 1), '0);
        both(1'b1, LA'(7), '0);
        both(1'b0, LA'(7), '0);

        // R7 requests injected mid-operation, then the other line read back
        run_op(1'b1, 1'b0, LA'(3), '0, 1'b1);
        both(1'b0, ~LA'(3), '0);
        d = rand_line();
        run_op(1'b0, 1'b1, LA'(9), d, 1'b1);
        run_op(1'b1, 1'b1, LA'(9), d, 1'b1);
        both(1'b0, ~LA'(9), '0);
        both(1'b0, LA'(9), '0);

        for (int k = 0; k < 30; k++) begin
            bit ilv, wr, poke;
            logic [LA-1:0] ln;
            ilv = 1'($urandom % 2);
            wr  = ($urandom % 3) == 0;
            poke = ($urandom % 4) == 0;
            ln = LA'($urandom % NL);
            d = rand_line();
            if (wr) begin
                run_op(1'b1, 1'b1, ln, d, poke);
                run_op(1'b0, 1'b1, ln, d, 1'b0);
            end else begin
                run_op(ilv, 1'b0, ln, '0, poke);
            end
        end

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule